// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block is a purely combinational integer ALU of parameterised width (32 bits by default). It takes two operands and a 3-bit function code and returns a result word together with a flag that is high when the result is zero. A processor datapath would place it between the register read ports and the write-back path. The function code would come from an instruction decoder.

One adder serves addition, subtraction and the signed set-less-than compare. The high function bit replaces the second operand with its bitwise complement and also sets the adder's carry-in, so the adder forms A + ~B + 1 = A - B. The same complemented operand reaches the AND and OR gates, which gives AND-with-complement and OR-with-complement at no extra cost. The low two function bits choose which of four internal results appears on the output. The result has no pipeline stage: it settles in the same cycle in which its operands are applied.

Top module: `shared_adder_alu`

## Requirements
- R1: Function code 000 gives the result A AND B.
- R2: Function code 001 gives the result A OR B.
- R3: Function code 010 gives A + B modulo 2^WIDTH. The carry out of the top bit is discarded.
- R4: Function code 110 gives A - B modulo 2^WIDTH, so equal operands give 0.
- R5: Function code 100 gives A AND (NOT B).
- R6: Function code 101 gives A OR (NOT B), so equal operands give all ones.
- R7: Function code 111 gives a result whose bits WIDTH-1..1 are 0 and whose bit 0 is bit WIDTH-1 of A - B. No overflow correction is applied, so the bit equals the signed comparison A < B XOR the signed overflow of A - B. For example, the most negative value compared with 1 gives 0.
- R8: Function code 011 gives a result whose bits WIDTH-1..1 are 0 and whose bit 0 is bit WIDTH-1 of A + B.
- R9: The zero flag is 1 exactly when all WIDTH bits of the result are 0.
- R10: The block holds no state. The result and the zero flag follow a change of the operands or of the function code without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, complemented internally when the function code's top bit is 1 |
| fnCode | input | 3 | Function code; bit 2 selects complement and carry-in, bits 1:0 select the output |
| result | output | WIDTH | Selected result |
| zeroFlag | output | 1 | High when result is all zeros |

## Verification
Every result and the zero flag are due in the same cycle as the stimulus that produces them, because no register lies between inputs and outputs. The bench drives operands and the function code just after a rising edge and compares them against its behavioural model at the following falling edge, half a period later, so each comparison sees settled values. One further check changes the inputs with no clock edge in between and samples a nanosecond later, which shows that nothing is held over from the previous cycle. The set-less-than model is built from a signed comparison corrected by an independently computed overflow term, so the cases where the sign of the difference gives the wrong answer are predicted rather than skipped.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // output selection, indexed by the low two function bits
  localparam int SEL_COUNT = 4;
  localparam int SEL_AND   = 0;
  localparam int SEL_OR    = 1;
  localparam int SEL_SUM   = 2;
  localparam int SEL_SIGN  = 3;

  // strobes passed from the function decoder to the datapath
  typedef struct packed {
    logic                 invertB;  // feed ~B to gates and adder
    logic                 carryIn;  // adder carry-in
    logic [SEL_COUNT-1:0] pickOut;  // one-hot output select
  } aluCtrl_t;

endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
  import alu_pkg::*;
(
  input  logic [2:0] fnCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.invertB = fnCode[2];
    ctrl.carryIn = fnCode[2];
    ctrl.pickOut = '0;
    unique case (fnCode[1:0])
      2'b00:   ctrl.pickOut[SEL_AND]  = 1'b1;
      2'b01:   ctrl.pickOut[SEL_OR]   = 1'b1;
      2'b10:   ctrl.pickOut[SEL_SUM]  = 1'b1;
      default: ctrl.pickOut[SEL_SIGN] = 1'b1;
    endcase
  end

  // R9 depends on exactly one source reaching the output
  always_comb begin
    p_one_source_r9: assert ($onehot(ctrl.pickOut))
      else $error("output select is not one-hot");
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] addX,
  input  logic [WIDTH-1:0] addY,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum
);

  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH-1:0] carry;
      assign carry[0] = carryIn;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i] = addX[i] ^ addY[i] ^ carry[i];
        if (i < WIDTH - 1) begin : g_next
          assign carry[i+1] = (addX[i] & addY[i]) | (carry[i] & (addX[i] ^ addY[i]));
        end
      end
    end else begin : g_infer
      assign sum = addX + addY + {{(WIDTH-1){1'b0}}, carryIn};
    end
  endgenerate

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] condB;
  logic [WIDTH-1:0] andRes;
  logic [WIDTH-1:0] orRes;
  logic [WIDTH-1:0] sumRes;
  logic [WIDTH-1:0] signRes;
  logic [WIDTH-1:0] srcVec [SEL_COUNT];

  assign condB   = ctrl.invertB ? ~opB : opB;
  assign andRes  = opA & condB;
  assign orRes   = opA | condB;
  assign signRes = {{(WIDTH-1){1'b0}}, sumRes[TOP]};

  alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) adder_i (
    .addX    (opA),
    .addY    (condB),
    .carryIn (ctrl.carryIn),
    .sum     (sumRes)
  );

  assign srcVec[SEL_AND]  = andRes;
  assign srcVec[SEL_OR]   = orRes;
  assign srcVec[SEL_SUM]  = sumRes;
  assign srcVec[SEL_SIGN] = signRes;

  // AND-OR mux over the one-hot select
  logic [WIDTH-1:0] masked [SEL_COUNT];
  generate
    for (genvar s = 0; s < SEL_COUNT; s++) begin : g_mask
      assign masked[s] = srcVec[s] & {WIDTH{ctrl.pickOut[s]}};
    end
  endgenerate

  always_comb begin
    result = '0;
    for (int s = 0; s < SEL_COUNT; s++) begin
      result = result | masked[s];
    end
  end

  assign zeroFlag = ~|result;

  always_comb begin
    // R7: compare result never sets an upper bit
    if (ctrl.pickOut[SEL_SIGN] && ctrl.invertB)
      p_compare_upper_clear_r7: assert (result[TOP:1] == '0)
        else $error("compare result has upper bits set");
    // R4: subtracting equal values leaves zero and raises the flag
    if (ctrl.pickOut[SEL_SUM] && ctrl.invertB && (opA == opB))
      p_sub_equal_zero_r4: assert (zeroFlag)
        else $error("A-A did not flag zero");
    // R6: A OR NOT A is all ones
    if (ctrl.pickOut[SEL_OR] && ctrl.invertB && (opA == opB))
      p_ornot_equal_ones_r6: assert (&result)
        else $error("A|~A not all ones");
    // R5: A AND NOT A is zero
    if (ctrl.pickOut[SEL_AND] && ctrl.invertB && (opA == opB))
      p_andnot_equal_zero_r5: assert (zeroFlag)
        else $error("A&~A not zero");
  end

endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       fnCode,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag
);

  aluCtrl_t ctrl;

  alu_fn_decode decode_i (
    .fnCode (fnCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) dp_i (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: tb/shared_adder_alu_tb.sv
module shared_adder_alu_tb_top;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [2:0]   fnCode = 3'd0;
  logic [W-1:0] result;
  logic         zeroFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  shared_adder_alu #(.WIDTH(W)) dut_i (
    .opA      (opA),
    .opB      (opB),
    .fnCode   (fnCode),
    .result   (result),
    .zeroFlag (zeroFlag)
  );

  // behavioural reference
  function automatic logic [W-1:0] refResult(input logic [W-1:0] x, input logic [W-1:0] y,
                                             input logic [2:0] f);
    logic [W-1:0] diff;
    logic [W-1:0] total;
    logic lt;
    logic ovf;
    diff  = x - y;
    total = x + y;
    lt    = $signed(x) < $signed(y);
    ovf   = (x[W-1] != y[W-1]) && (diff[W-1] != x[W-1]);
    case (f)
      3'd0:    return x & y;
      3'd1:    return x | y;
      3'd2:    return total;
      3'd3:    return {{(W-1){1'b0}}, total[W-1]};
      3'd4:    return x & ~y;
      3'd5:    return x | ~y;
      3'd6:    return diff;
      default: return {{(W-1){1'b0}}, lt ^ ovf};
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] f);
    case (f)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R8";
      3'd4:    return "R5";
      3'd5:    return "R6";
      3'd6:    return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (A=%h B=%h F=%0d)", req, got, exp, opA, opB, fnCode);
    end
  endtask

  task automatic applyAndCheck(input logic [W-1:0] x, input logic [W-1:0] y, input logic [2:0] f);
    logic [W-1:0] exp;
    @(posedge clk);
    #1;
    opA = x;
    opB = y;
    fnCode = f;
    exp = refResult(x, y, f);
    @(negedge clk);  // zero latency: due within the same cycle
    checkVal(reqOf(f), result, exp);
    checkVal("R9", {{(W-1){1'b0}}, zeroFlag}, {{(W-1){1'b0}}, (exp == '0)});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] edges [5];
    edges[0] = '0;
    edges[1] = '1;
    edges[2] = {1'b1, {(W-1){1'b0}}};
    edges[3] = {1'b0, {(W-1){1'b1}}};
    edges[4] = {{(W-1){1'b0}}, 1'b1};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero inputs, AND code
    checkVal("R1", result, '0);
    checkVal("R9", {{(W-1){1'b0}}, zeroFlag}, {{(W-1){1'b0}}, 1'b1});
    rstN = 1'b1;

    // every code over every edge pair
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          applyAndCheck(edges[i], edges[j], 3'(f));

    // R7 directed overflow cases: sign of difference gives the wrong answer
    applyAndCheck({1'b1, {(W-1){1'b0}}}, {{(W-1){1'b0}}, 1'b1}, 3'd7);
    checkVal("R7", result, '0);
    applyAndCheck({1'b0, {(W-1){1'b1}}}, '1, 3'd7);
    checkVal("R7", result, {{(W-1){1'b0}}, 1'b1});
    // R3 wrap-around
    applyAndCheck('1, {{(W-1){1'b0}}, 1'b1}, 3'd2);
    checkVal("R3", result, '0);

    // random operands, all codes
    for (int n = 0; n < 2000; n++)
      applyAndCheck($urandom, $urandom, 3'($urandom_range(0, 7)));

    // R10: output follows inputs with no clock edge in between
    @(posedge clk);
    #0.5;
    opA = 32'h0000_00F0;
    opB = 32'h0000_000F;
    fnCode = 3'd1;
    #1;
    checkVal("R10", result, 32'h0000_00FF);
    fnCode = 3'd0;
    #1;
    checkVal("R10", result, '0);
    checkVal("R10", {{(W-1){1'b0}}, zeroFlag}, {{(W-1){1'b0}}, 1'b1});

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule